// File: doc/BRIEF.md
# Interleaved ADC Channel Slot Sequencer

This block drives the control side of a shared successive-approximation converter. Time is cut into fixed slots of 20 converter clock cycles, 2 µs each at a 10 MHz clock. Every slot opens with a 4-cycle sample window and then runs a 16-cycle conversion window. The external inputs and one internal input share the converter. The internal input gets every second slot, and the external inputs take the other slots in ascending order. The full pattern of 8 slots repeats every 16 µs.

At the end of each slot the converter's result bus is captured. The captured word goes into a per-channel result register, and it is also presented on a tagged result output together with a one-cycle valid strobe. An enable mask can switch off individual external inputs. The slot of a switched-off input still runs with normal timing, but no result is stored for it. The analog converter itself is not part of this block.

Top module: `adc_slot_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after a reset edge, sample_en, conv_en and res_valid are 0, chan_sel is 0 and every result register reads 0.
- R2: Once reset is released, each slot lasts 20 cycles: sample_en is high for the first 4 and conv_en for the remaining 16, and exactly one of the two is high in every cycle.
- R3: Slot channels follow ext0, int, ext1, int, ext2, int, ext3, int and then repeat, so the pattern takes 160 cycles. chan_sel encodes external input k as value k and the internal input as value 4.
- R4: chan_sel does not change within a slot.
- R5: At the clock edge that ends the last conversion cycle of a slot, adc_data is captured. In the following cycle res_valid is high for exactly one cycle, with res_tag equal to that slot's chan_sel and res_data equal to the captured word.
- R6: The same capture writes the result register of that channel. Channel k occupies chan_results bits [k*12 +: 12], and the internal input uses index 4.
- R7: en_mask bit k enables external input k and is sampled at the capture edge. For a disabled input the slot timing is unchanged, no valid strobe is raised and its result register keeps its old value.
- R8: The internal input is captured in every one of its slots, whatever en_mask holds.
- R9: A reset asserted during operation clears the block, and the first cycle after release is the sample phase of the ext0 slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock (10 MHz in the target system) |
| rst | input | 1 | Synchronous reset, active high |
| en_mask | input | 4 | Per-external-input enable, bit k for input k |
| adc_data | input | 12 | Result bus from the converter |
| chan_sel | output | 3 | Channel selected for the current slot |
| sample_en | output | 1 | Sample window active |
| conv_en | output | 1 | Conversion window active |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_tag | output | 3 | Channel code of the result |
| res_data | output | 12 | Captured result word |
| chan_results | output | 60 | Per-channel result registers, 12 bits per channel, internal at index 4 |

## Verification
The control outputs pass through one register stage behind the slot counter. The n-th cycle after reset release therefore shows the phase and channel of slot-cycle n-1, and the bench derives both from its own count of clock edges since reset. The bench drives the converter word and decides, at the falling edge inside each slot's last conversion cycle, whether a result is due. If it is, the expected tag and data go into a queue. The result strobe and the matching result-register update arrive after the next rising edge, so the monitor pops and compares them at the very next falling edge. A strobe with nothing queued, or a queued item with no strobe, counts as a failure.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Channel code of a slot: even slots walk the external inputs in order,
  // odd slots belong to the internal input whose code is n_ext.
  function automatic int slot_to_tag(int slot, int n_ext);
    if ((slot % 2) == 0) return slot / 2;
    return n_ext;
  endfunction

  // True while a cycle index lies inside the sample window.
  function automatic bit cycle_in_sample(int cyc, int sample_cyc);
    return cyc < sample_cyc;
  endfunction

  // True on the final conversion cycle of a slot.
  function automatic bit cycle_is_last(int cyc, int slot_cyc);
    return cyc == (slot_cyc - 1);
  endfunction

  // Next slot index with wrap at the pattern length.
  function automatic int next_slot(int slot, int n_slots);
    if (slot == n_slots - 1) return 0;
    return slot + 1;
  endfunction

endpackage

// File: rtl/adc_slot_timer.sv
module adc_slot_timer #(
  parameter int SLOT_CYC = 20,
  parameter int N_SLOTS  = 8,
  localparam int CYC_W   = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
  localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [CYC_W-1:0]  cyc_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_end_o
);
  import adc_seq_pkg::*;

  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] slot_q;

  assign slot_end_o = cycle_is_last(int'(cyc_q), SLOT_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (slot_end_o) begin
      cyc_q  <= '0;
      slot_q <= SLOT_W'(next_slot(int'(slot_q), N_SLOTS));
    end else begin
      cyc_q  <= cyc_q + CYC_W'(1);
    end
  end

  assign cyc_o  = cyc_q;
  assign slot_o = slot_q;

endmodule

// File: rtl/adc_phase_stage.sv
module adc_phase_stage #(
  parameter int N_EXT      = 4,
  parameter int SAMPLE_CYC = 4,
  parameter int SLOT_CYC   = 20,
  parameter int N_SLOTS    = 8,
  localparam int CYC_W     = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
  localparam int SLOT_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int TAG_W     = $clog2(N_EXT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              sample_en_o,
  output logic              conv_en_o,
  output logic [TAG_W-1:0]  chan_sel_o,
  output logic              last_conv_o
);
  import adc_seq_pkg::*;

  logic             in_sample;
  logic             is_last;
  logic [TAG_W-1:0] slot_tag;

  always_comb begin
    in_sample = cycle_in_sample(int'(cyc_i), SAMPLE_CYC);
    is_last   = cycle_is_last(int'(cyc_i), SLOT_CYC);
    slot_tag  = TAG_W'(slot_to_tag(int'(slot_i), N_EXT));
  end

  // One register stage so every control output leaves a flop and all of
  // them are forced low while reset is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_en_o <= 1'b0;
      conv_en_o   <= 1'b0;
      chan_sel_o  <= '0;
      last_conv_o <= 1'b0;
    end else begin
      sample_en_o <= in_sample;
      conv_en_o   <= !in_sample;
      chan_sel_o  <= slot_tag;
      last_conv_o <= is_last;
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int N_EXT  = 4,
  parameter int DATA_W = 12,
  localparam int N_CH  = N_EXT + 1,
  localparam int TAG_W = $clog2(N_EXT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   last_conv_i,
  input  logic [TAG_W-1:0]       chan_sel_i,
  input  logic [N_EXT-1:0]       en_mask_i,
  input  logic [DATA_W-1:0]      adc_data_i,
  output logic                   capture_o,
  output logic                   res_valid_o,
  output logic [TAG_W-1:0]       res_tag_o,
  output logic [DATA_W-1:0]      res_data_o,
  output logic [N_CH*DATA_W-1:0] bank_o
);

  logic [N_CH-1:0] sel_onehot;
  logic            sel_enabled;

  // Decode the selected channel and look up its enable.
  always_comb begin
    sel_onehot  = '0;
    sel_enabled = 1'b0;
    for (int k = 0; k < N_CH; k++) begin
      if (chan_sel_i == TAG_W'(k)) begin
        sel_onehot[k] = 1'b1;
        if (k == N_EXT) sel_enabled = 1'b1;
        else            sel_enabled = en_mask_i[k];
      end
    end
  end

  assign capture_o = last_conv_i && sel_enabled;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      res_tag_o   <= '0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= capture_o;
      if (capture_o) begin
        res_tag_o  <= chan_sel_i;
        res_data_o <= adc_data_i;
      end
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_entry
    logic [DATA_W-1:0] entry_q;
    logic              wr_en;
    assign wr_en = capture_o && sel_onehot[k];
    always_ff @(posedge clk) begin
      if (rst)        entry_q <= '0;
      else if (wr_en) entry_q <= adc_data_i;
    end
    assign bank_o[k*DATA_W +: DATA_W] = entry_q;
  end

endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer #(
  parameter int N_EXT      = 4,
  parameter int SAMPLE_CYC = 4,
  parameter int CONV_CYC   = 16,
  parameter int DATA_W     = 12,
  localparam int N_CH      = N_EXT + 1,
  localparam int TAG_W     = $clog2(N_EXT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_EXT-1:0]       en_mask,
  input  logic [DATA_W-1:0]      adc_data,
  output logic [TAG_W-1:0]       chan_sel,
  output logic                   sample_en,
  output logic                   conv_en,
  output logic                   res_valid,
  output logic [TAG_W-1:0]       res_tag,
  output logic [DATA_W-1:0]      res_data,
  output logic [N_CH*DATA_W-1:0] chan_results
);

  localparam int SLOT_CYC = SAMPLE_CYC + CONV_CYC;
  localparam int N_SLOTS  = 2 * N_EXT;
  localparam int CYC_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int SLOT_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  // Named internal events, visible to the bound checker.
  logic [CYC_W-1:0]  slot_cyc;
  logic [SLOT_W-1:0] slot_idx;
  logic              slot_end;
  logic              last_conv;
  logic              capture;

  adc_slot_timer #(
    .SLOT_CYC (SLOT_CYC),
    .N_SLOTS  (N_SLOTS)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .cyc_o      (slot_cyc),
    .slot_o     (slot_idx),
    .slot_end_o (slot_end)
  );

  adc_phase_stage #(
    .N_EXT      (N_EXT),
    .SAMPLE_CYC (SAMPLE_CYC),
    .SLOT_CYC   (SLOT_CYC),
    .N_SLOTS    (N_SLOTS)
  ) u_phase (
    .clk         (clk),
    .rst         (rst),
    .cyc_i       (slot_cyc),
    .slot_i      (slot_idx),
    .sample_en_o (sample_en),
    .conv_en_o   (conv_en),
    .chan_sel_o  (chan_sel),
    .last_conv_o (last_conv)
  );

  adc_result_bank #(
    .N_EXT  (N_EXT),
    .DATA_W (DATA_W)
  ) u_bank (
    .clk         (clk),
    .rst         (rst),
    .last_conv_i (last_conv),
    .chan_sel_i  (chan_sel),
    .en_mask_i   (en_mask),
    .adc_data_i  (adc_data),
    .capture_o   (capture),
    .res_valid_o (res_valid),
    .res_tag_o   (res_tag),
    .res_data_o  (res_data),
    .bank_o      (chan_results)
  );

endmodule

// File: rtl/adc_slot_sequencer_chk.sv
module adc_slot_sequencer_chk #(
  parameter int N_EXT      = 4,
  parameter int SAMPLE_CYC = 4,
  parameter int CONV_CYC   = 16,
  parameter int DATA_W     = 12,
  localparam int TAG_W     = $clog2(N_EXT + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [N_EXT-1:0]  en_mask,
  input logic [DATA_W-1:0] adc_data,
  input logic [TAG_W-1:0]  chan_sel,
  input logic              sample_en,
  input logic              conv_en,
  input logic              res_valid,
  input logic [TAG_W-1:0]  res_tag,
  input logic [DATA_W-1:0] res_data,
  input logic              last_conv
);

  localparam logic [TAG_W-1:0] INT_TAG = TAG_W'(N_EXT);

  logic [15:0] samp_run;
  logic [15:0] conv_run;
  logic        sel_on;

  always_comb begin
    sel_on = (chan_sel == INT_TAG);
    for (int k = 0; k < N_EXT; k++)
      if (chan_sel == TAG_W'(k)) sel_on = en_mask[k];
  end

  // Window-length counters, so no parameter-deep $past is needed.
  always_ff @(posedge clk) begin
    if (rst) begin
      samp_run <= '0;
      conv_run <= '0;
    end else begin
      samp_run <= sample_en ? samp_run + 16'd1 : 16'd0;
      conv_run <= conv_en   ? conv_run + 16'd1 : 16'd0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!sample_en && !conv_en && !res_valid && chan_sel == '0));

  assert_one_phase_R2: assert property (@(posedge clk)
    !rst |=> (sample_en != conv_en));

  assert_sample_len_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(sample_en) && conv_en) |-> (samp_run == 16'(SAMPLE_CYC)));

  assert_conv_len_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(conv_en) && sample_en) |-> (conv_run == 16'(CONV_CYC)));

  assert_alternate_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sample_en) && $past(conv_en)) |->
      (($past(chan_sel) == INT_TAG) != (chan_sel == INT_TAG)));

  assert_chan_hold_R4: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> $stable(chan_sel));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_valid_source_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(last_conv) && $past(conv_en) &&
                   res_tag == $past(chan_sel) && res_data == $past(adc_data)));

  assert_masked_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (last_conv && !sel_on) |=> !res_valid);

  assert_internal_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (last_conv && chan_sel == INT_TAG) |=> (res_valid && res_tag == INT_TAG));

endmodule

bind adc_slot_sequencer adc_slot_sequencer_chk #(
  .N_EXT      (N_EXT),
  .SAMPLE_CYC (SAMPLE_CYC),
  .CONV_CYC   (CONV_CYC),
  .DATA_W     (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_mask   (en_mask),
  .adc_data  (adc_data),
  .chan_sel  (chan_sel),
  .sample_en (sample_en),
  .conv_en   (conv_en),
  .res_valid (res_valid),
  .res_tag   (res_tag),
  .res_data  (res_data),
  .last_conv (last_conv)
);

// File: tb/test_adc_slot_sequencer.sv
module test_adc_slot_sequencer;

  localparam int NE = 4;
  localparam int DW = 12;
  localparam int NC = NE + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NE-1:0]  en_mask = '1;
  logic [DW-1:0]  adc_data = '0;
  logic [2:0]     chan_sel;
  logic           sample_en;
  logic           conv_en;
  logic           res_valid;
  logic [2:0]     res_tag;
  logic [DW-1:0]  res_data;
  logic [NC*DW-1:0] chan_results;

  always #2 clk = ~clk;

  adc_slot_sequencer i_adc_slot_sequencer (
    .clk          (clk),
    .rst          (rst),
    .en_mask      (en_mask),
    .adc_data     (adc_data),
    .chan_sel     (chan_sel),
    .sample_en    (sample_en),
    .conv_en      (conv_en),
    .res_valid    (res_valid),
    .res_tag      (res_tag),
    .res_data     (res_data),
    .chan_results (chan_results)
  );

  typedef struct { int tag; int data; } item_t;
  item_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  int ph     = 0;
  int resets = 0;
  int prev_sel = 0;
  bit finished = 0;
  int shadow [NC];

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Edge counter since reset release; expectations are dropped on reset.
  always @(posedge clk) begin
    if (rst) begin
      ph <= 0;
      exp_q.delete();
    end else begin
      ph <= ph + 1;
    end
  end

  // Model, monitor and converter driver, all away from the rising edge.
  always @(negedge clk) begin
    if (ph == 0) begin
      check(sample_en == 1'b0, "R1", "sample_en in reset", int'(sample_en), 0);
      check(conv_en == 1'b0, "R1", "conv_en in reset", int'(conv_en), 0);
      check(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
      check(chan_sel == 3'd0, "R1", "chan_sel in reset", int'(chan_sel), 0);
      for (int k = 0; k < NC; k++) begin
        shadow[k] = 0;
        check(chan_results[k*DW +: DW] == '0, "R1", "bank cleared",
              int'(chan_results[k*DW +: DW]), 0);
      end
    end else begin
      int g, c, s, tag;
      g   = ph - 1;
      c   = g % 20;
      s   = (g / 20) % 8;
      tag = ((s % 2) == 0) ? s / 2 : NE;

      check(sample_en == (c < 4), "R2", "sample_en", int'(sample_en), int'(c < 4));
      check(conv_en == (c >= 4), "R2", "conv_en", int'(conv_en), int'(c >= 4));
      if (ph == 1 && resets > 1)
        check(int'(chan_sel) == tag, "R9", "chan_sel after mid-run reset", int'(chan_sel), tag);
      else
        check(int'(chan_sel) == tag, "R3", "chan_sel order", int'(chan_sel), tag);
      if (c != 0)
        check(int'(chan_sel) == prev_sel, "R4", "chan_sel held in slot", int'(chan_sel), prev_sel);

      // Monitor: an item pushed at the previous falling edge is due now.
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected res_valid tag", int'(res_tag), -1);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(int'(res_tag) == e.tag, (e.tag == NE) ? "R8" : "R5", "res_tag", int'(res_tag), e.tag);
          check(int'(res_data) == e.data, "R5", "res_data", int'(res_data), e.data);
          shadow[e.tag] = e.data;
        end
      end else if (exp_q.size() != 0) begin
        item_t e;
        e = exp_q.pop_front();
        check(1'b0, (e.tag == NE) ? "R8" : "R5", "missing res_valid for tag", 0, e.tag);
      end

      for (int k = 0; k < NC; k++)
        check(int'(chan_results[k*DW +: DW]) == shadow[k], "R6", "result register",
              int'(chan_results[k*DW +: DW]), shadow[k]);

      // Driver: new converter word each cycle; queue a result on the last cycle.
      adc_data = DW'((g * 173 + 29) ^ (g >> 3));
      if (c == 19 && (tag == NE || en_mask[tag]))
        exp_q.push_back('{tag: tag, data: int'(adc_data)});
    end
    prev_sel = int'(chan_sel);
  end

  task automatic run_cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1;
    resets = 1;
    run_cycles(3);
    rst = 1'b0;
    // All inputs enabled: two full patterns and a bit (R3, R5, R6).
    run_cycles(330);
    // Inputs 0 and 2 only (R7).
    en_mask = 4'b0101;
    run_cycles(340);
    // Everything off: only the internal input converts (R8).
    en_mask = 4'b0000;
    run_cycles(170);
    // Mask change mid-slot, then a reset in the middle of a slot (R9).
    en_mask = 4'b1010;
    run_cycles(107);
    rst = 1'b1;
    resets = resets + 1;
    run_cycles(3);
    rst = 1'b0;
    en_mask = 4'b1111;
    run_cycles(200);
    finish_run();
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

endmodule